// File: doc/BRIEF.md
# Clock Output Stop and Gating Controller

This block decides, output by output, whether each clock of a clock generator toggles, sits driven low, or floats. The outputs fall into three groups, each running from its own source clock: processor clocks, single-ended bus clocks and serial-link clocks. The last group includes one storage-link clock. Stop requests come from several places. There is a processor stop pin, a bus/serial stop pin together with a matching configuration bit, two clock-request pins and a power-down input. All of these are asynchronous to the output clocks. Static configuration inputs supply the per-output enable bits and the stoppable masks. They also supply the per-cause choice between driven-low and high-impedance, and the selection of which serial outputs each request pin controls.

Every stop source is re-timed by a two-stage synchroniser in the clock domain of the group it affects. The per-output gate is then updated on the falling edge of that clock, so it only changes while the clock is low. Each gated output is the source clock ANDed with its gate. Pulses therefore always have full width, and a restarted output begins with a rising edge. Next to each gate the block produces a high-impedance control for the processor and serial groups. The bus group is always driven low when stopped. Clock synthesis and the analog drivers sit outside the block.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `cpu_stop_n` is low, every processor output whose `cfg_cpu_stoppable` bit is 1 is stopped. Processor outputs with the bit at 0 keep toggling.
- R2: While `pci_stop_n` is low or `cfg_pci_stop` is 1, bus and serial outputs whose stoppable bit is 1 are stopped at logic 0. Outputs with the bit at 0 keep toggling.
- R3: The high-impedance control of a stopped output follows its stop cause. Processor stop uses the per-output bit `cfg_cpustop_hiz`, serial stop through the bus stop uses `cfg_pcistop_hiz`, and power-down uses `cfg_pd_hiz_cpu` or `cfg_pd_hiz_src`; 0 means driven low and 1 means high-impedance. A running output is never high-impedance, and bus outputs have no high-impedance state.
- R4: While `clkreq_a_n` is high, each serial output i with `cfg_reqa_sel[i]`=1 and `REQA_MASK[i]`=1 is stopped and high-impedance. The default mask allows positions 0, 2 and 4.
- R5: While `clkreq_b_n` is high, each serial output i with `cfg_reqb_sel[i]`=1 and `REQB_MASK[i]`=1 is stopped and high-impedance. The default mask allows positions 1, 3 and 7, where 7 is the storage-link clock.
- R6: An output whose enable bit is 0 is stopped regardless of every stop pin.
- R7: While `pwrdn` is high, every output of every group is stopped.
- R8: A change on a stop source is seen by the gate at the falling edge that follows the second rising edge of the group clock after the change. Gates change only while their clock is low, so every gated pulse is a full half period, and a restarted output starts with a rising edge.
- R9: While `rst_n` is low, all gates and high-impedance controls are 0. With no stop pending, gates open at the first falling edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Processor group source clock |
| clk_pci | input | 1 | Bus group source clock |
| clk_src | input | 1 | Serial group source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Processor stop pin, active low |
| pci_stop_n | input | 1 | Bus/serial stop pin, active low |
| clkreq_a_n | input | 1 | Request pin A; high releases selected serial outputs to Hi-Z |
| clkreq_b_n | input | 1 | Request pin B; high releases selected serial outputs to Hi-Z |
| pwrdn | input | 1 | Power-down, active high, asynchronous |
| cfg_cpu_en | input | N_CPU | Processor output enables |
| cfg_cpu_stoppable | input | N_CPU | 1 = processor output obeys the processor stop |
| cfg_cpustop_hiz | input | N_CPU | Per-output Hi-Z choice under processor stop |
| cfg_pd_hiz_cpu | input | 1 | Processor group Hi-Z choice under power-down |
| cfg_pci_en | input | N_PCI | Bus output enables |
| cfg_pci_stoppable | input | N_PCI | 1 = bus output obeys the bus stop |
| cfg_pci_stop | input | 1 | Register form of the bus stop |
| cfg_src_en | input | N_SRC | Serial output enables |
| cfg_src_stoppable | input | N_SRC | 1 = serial output obeys the bus stop |
| cfg_pcistop_hiz | input | 1 | Serial group Hi-Z choice under bus stop |
| cfg_pd_hiz_src | input | 1 | Serial group Hi-Z choice under power-down |
| cfg_reqa_sel | input | N_SRC | Serial outputs controlled by request pin A |
| cfg_reqb_sel | input | N_SRC | Serial outputs controlled by request pin B |
| cpu_gate | output | N_CPU | Processor clock gates, 1 = running |
| cpu_hiz | output | N_CPU | Processor Hi-Z controls |
| cpu_ck_o | output | N_CPU | Gated processor clocks |
| pci_gate | output | N_PCI | Bus clock gates |
| pci_ck_o | output | N_PCI | Gated bus clocks |
| src_gate | output | N_SRC | Serial clock gates |
| src_hiz | output | N_SRC | Serial Hi-Z controls |
| src_ck_o | output | N_SRC | Gated serial clocks |

## Verification
The assertions assume that every configuration input is held still while the block is out of reset. They also assume that stop pins and power-down stay at one level long enough for the two-stage synchroniser to see them. The stimulus follows both assumptions. It changes configuration only while reset is held. It changes pins a millisecond-free few clock cycles apart, always half a cycle away from the slowest group's rising edge, and it waits four slow-clock cycles before sampling. Within those limits the sweep covers all 32 combinations of the five stop pins for each of four configuration sets. It compares gates, high-impedance controls and gated edge counts against counts derived from the requirements.

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int N_CPU = 3,
  parameter int N_PCI = 6,
  parameter int N_SRC = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [N_SRC-1:0] REQA_MASK = 8'b0001_0101,
  parameter logic [N_SRC-1:0] REQB_MASK = 8'b1000_1010
) (
  input  logic             clk_cpu,
  input  logic             clk_pci,
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             clkreq_a_n,
  input  logic             clkreq_b_n,
  input  logic             pwrdn,
  input  logic [N_CPU-1:0] cfg_cpu_en,
  input  logic [N_CPU-1:0] cfg_cpu_stoppable,
  input  logic [N_CPU-1:0] cfg_cpustop_hiz,
  input  logic             cfg_pd_hiz_cpu,
  input  logic [N_PCI-1:0] cfg_pci_en,
  input  logic [N_PCI-1:0] cfg_pci_stoppable,
  input  logic             cfg_pci_stop,
  input  logic [N_SRC-1:0] cfg_src_en,
  input  logic [N_SRC-1:0] cfg_src_stoppable,
  input  logic             cfg_pcistop_hiz,
  input  logic             cfg_pd_hiz_src,
  input  logic [N_SRC-1:0] cfg_reqa_sel,
  input  logic [N_SRC-1:0] cfg_reqb_sel,
  output logic [N_CPU-1:0] cpu_gate,
  output logic [N_CPU-1:0] cpu_hiz,
  output logic [N_CPU-1:0] cpu_ck_o,
  output logic [N_PCI-1:0] pci_gate,
  output logic [N_PCI-1:0] pci_ck_o,
  output logic [N_SRC-1:0] src_gate,
  output logic [N_SRC-1:0] src_hiz,
  output logic [N_SRC-1:0] src_ck_o
);

  localparam int LAST = SYNC_STAGES - 1;

  // CPU domain: {power-down, cpu stop}
  logic [1:0] cpu_raw;
  logic [SYNC_STAGES-1:0][1:0] cpu_sync;
  assign cpu_raw = {pwrdn, ~cpu_stop_n};

  always_ff @(posedge clk_cpu or negedge rst_n)
    if (!rst_n) cpu_sync <= '0;
    else        cpu_sync <= {cpu_sync[LAST-1:0], cpu_raw};

  logic             cpu_pd, cpu_stp;
  logic [N_CPU-1:0] cpu_halt, cpu_hiz_nx;
  assign cpu_pd     = cpu_sync[LAST][1];
  assign cpu_stp    = cpu_sync[LAST][0];
  assign cpu_halt   = {N_CPU{cpu_pd}} | ~cfg_cpu_en | ({N_CPU{cpu_stp}} & cfg_cpu_stoppable);
  assign cpu_hiz_nx = cpu_pd ? {N_CPU{cfg_pd_hiz_cpu}}
                             : (cfg_cpu_en & {N_CPU{cpu_stp}} & cfg_cpu_stoppable & cfg_cpustop_hiz);

  always_ff @(negedge clk_cpu or negedge rst_n)
    if (!rst_n) begin
      cpu_gate <= '0;
      cpu_hiz  <= '0;
    end else begin
      cpu_gate <= ~cpu_halt;
      cpu_hiz  <= cpu_hiz_nx;
    end

  assign cpu_ck_o = {N_CPU{clk_cpu}} & cpu_gate;

  // PCI domain: {power-down, pci stop}
  logic [1:0] pci_raw;
  logic [SYNC_STAGES-1:0][1:0] pci_sync;
  assign pci_raw = {pwrdn, ~pci_stop_n};

  always_ff @(posedge clk_pci or negedge rst_n)
    if (!rst_n) pci_sync <= '0;
    else        pci_sync <= {pci_sync[LAST-1:0], pci_raw};

  logic             pci_pd, pci_stp;
  logic [N_PCI-1:0] pci_halt;
  assign pci_pd   = pci_sync[LAST][1];
  assign pci_stp  = pci_sync[LAST][0] | cfg_pci_stop;
  assign pci_halt = {N_PCI{pci_pd}} | ~cfg_pci_en | ({N_PCI{pci_stp}} & cfg_pci_stoppable);

  always_ff @(negedge clk_pci or negedge rst_n)
    if (!rst_n) pci_gate <= '0;
    else        pci_gate <= ~pci_halt;

  assign pci_ck_o = {N_PCI{clk_pci}} & pci_gate;

  // Serial domain: {power-down, pci stop, request A released, request B released}
  logic [3:0] src_raw;
  logic [SYNC_STAGES-1:0][3:0] src_sync;
  assign src_raw = {pwrdn, ~pci_stop_n, clkreq_a_n, clkreq_b_n};

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) src_sync <= '0;
    else        src_sync <= {src_sync[LAST-1:0], src_raw};

  logic             src_pd, src_stp, src_ra, src_rb;
  logic [N_SRC-1:0] src_off, src_pstop, src_halt, src_hiz_nx;
  assign src_pd     = src_sync[LAST][3];
  assign src_stp    = src_sync[LAST][2] | cfg_pci_stop;
  assign src_ra     = src_sync[LAST][1];
  assign src_rb     = src_sync[LAST][0];
  assign src_off    = ({N_SRC{src_ra}} & cfg_reqa_sel & REQA_MASK)
                    | ({N_SRC{src_rb}} & cfg_reqb_sel & REQB_MASK);
  assign src_pstop  = {N_SRC{src_stp}} & cfg_src_stoppable;
  assign src_halt   = {N_SRC{src_pd}} | ~cfg_src_en | src_pstop | src_off;
  assign src_hiz_nx = src_off | (src_pd ? {N_SRC{cfg_pd_hiz_src}}
                                        : (cfg_src_en & src_pstop & {N_SRC{cfg_pcistop_hiz}}));

  always_ff @(negedge clk_src or negedge rst_n)
    if (!rst_n) begin
      src_gate <= '0;
      src_hiz  <= '0;
    end else begin
      src_gate <= ~src_halt;
      src_hiz  <= src_hiz_nx;
    end

  assign src_ck_o = {N_SRC{clk_src}} & src_gate;

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int N_CPU = 3,
  parameter int N_PCI = 6,
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] REQA_MASK = 8'b0001_0101,
  parameter logic [N_SRC-1:0] REQB_MASK = 8'b1000_1010
) (
  input logic             clk_cpu,
  input logic             clk_pci,
  input logic             clk_src,
  input logic             rst_n,
  input logic             cpu_stop_n,
  input logic             pci_stop_n,
  input logic             clkreq_a_n,
  input logic             clkreq_b_n,
  input logic             pwrdn,
  input logic [N_CPU-1:0] cfg_cpu_en,
  input logic [N_CPU-1:0] cfg_cpu_stoppable,
  input logic [N_PCI-1:0] cfg_pci_en,
  input logic [N_PCI-1:0] cfg_pci_stoppable,
  input logic [N_SRC-1:0] cfg_src_stoppable,
  input logic [N_SRC-1:0] cfg_reqa_sel,
  input logic [N_SRC-1:0] cfg_reqb_sel,
  input logic [N_CPU-1:0] cpu_gate,
  input logic [N_PCI-1:0] pci_gate,
  input logic [N_SRC-1:0] src_gate,
  input logic [N_SRC-1:0] src_hiz
);

  logic [1:0] up_cpu, up_pci, up_src;
  logic [N_CPU-1:0] cpu_gate_rise;

  always_ff @(posedge clk_cpu or negedge rst_n)
    if (!rst_n) begin
      up_cpu <= '0;
      cpu_gate_rise <= '0;
    end else begin
      if (up_cpu != 2'd3) up_cpu <= up_cpu + 2'd1;
      cpu_gate_rise <= cpu_gate;
    end

  always_ff @(posedge clk_pci or negedge rst_n)
    if (!rst_n) up_pci <= '0;
    else if (up_pci != 2'd3) up_pci <= up_pci + 2'd1;

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) up_src <= '0;
    else if (up_src != 2'd3) up_src <= up_src + 2'd1;

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    p_cpu_stop_r1: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (up_cpu == 2'd3 && cfg_cpu_stoppable[i] && !$past(cpu_stop_n, 2)) |-> !cpu_gate[i]);
    p_cpu_free_r1: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (up_cpu == 2'd3 && cfg_cpu_en[i] && !cfg_cpu_stoppable[i] && !$past(pwrdn, 2)) |-> cpu_gate[i]);
    p_cpu_disabled_r6: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (up_cpu == 2'd3 && !cfg_cpu_en[i]) |-> !cpu_gate[i]);
  end

  p_cpu_pd_r7: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    (up_cpu == 2'd3 && $past(pwrdn, 2)) |-> cpu_gate == '0);

  p_gate_low_phase_r8: assert property (@(negedge clk_cpu) disable iff (!rst_n)
    cpu_gate == cpu_gate_rise);

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    p_pci_free_r2: assert property (@(posedge clk_pci) disable iff (!rst_n)
      (up_pci == 2'd3 && cfg_pci_en[i] && !cfg_pci_stoppable[i] && !$past(pwrdn, 2)) |-> pci_gate[i]);
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    p_src_pcistop_r2: assert property (@(posedge clk_src) disable iff (!rst_n)
      (up_src == 2'd3 && cfg_src_stoppable[i] && !$past(pci_stop_n, 2)) |-> !src_gate[i]);
    p_reqa_hiz_r4: assert property (@(posedge clk_src) disable iff (!rst_n)
      (up_src == 2'd3 && REQA_MASK[i] && cfg_reqa_sel[i] && $past(clkreq_a_n, 2)) |-> (src_hiz[i] && !src_gate[i]));
    p_reqb_hiz_r5: assert property (@(posedge clk_src) disable iff (!rst_n)
      (up_src == 2'd3 && REQB_MASK[i] && cfg_reqb_sel[i] && $past(clkreq_b_n, 2)) |-> (src_hiz[i] && !src_gate[i]));
  end

  p_src_pd_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
    (up_src == 2'd3 && $past(pwrdn, 2)) |-> src_gate == '0);

  p_hiz_only_stopped_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
    (src_hiz & src_gate) == '0);

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .N_SRC(N_SRC),
  .REQA_MASK(REQA_MASK), .REQB_MASK(REQB_MASK)
) u_chk (.*);

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3, NP = 6, NS = 8;
  localparam logic [NS-1:0] MA = 8'b0001_0101;
  localparam logic [NS-1:0] MB = 8'b1000_1010;

  logic clk_cpu = 0, clk_pci = 0, clk_src = 0, rst_n = 0;
  logic cpu_stop_n = 1, pci_stop_n = 1, clkreq_a_n = 0, clkreq_b_n = 0, pwrdn = 0;
  logic [NC-1:0] cfg_cpu_en = '1, cfg_cpu_stoppable = '0, cfg_cpustop_hiz = '0;
  logic cfg_pd_hiz_cpu = 0, cfg_pci_stop = 0, cfg_pcistop_hiz = 0, cfg_pd_hiz_src = 0;
  logic [NP-1:0] cfg_pci_en = '1, cfg_pci_stoppable = '0;
  logic [NS-1:0] cfg_src_en = '1, cfg_src_stoppable = '0, cfg_reqa_sel = '0, cfg_reqb_sel = '0;
  logic [NC-1:0] cpu_gate, cpu_hiz, cpu_ck_o;
  logic [NP-1:0] pci_gate, pci_ck_o;
  logic [NS-1:0] src_gate, src_hiz, src_ck_o;

  always #(CLK_PERIOD/2) clk_cpu = ~clk_cpu;
  always #(3*CLK_PERIOD/2) clk_pci = ~clk_pci;
  always #(CLK_PERIOD) clk_src = ~clk_src;

  clk_stop_ctrl u_dut (.*);

  int n_chk = 0, n_bad = 0;
  int ref_c = 0, ref_p = 0, ref_s = 0, runts = 0;
  int ec [NC];
  int ep [NP];
  int es [NS];

  initial begin
    for (int i = 0; i < NC; i++) ec[i] = 0;
    for (int i = 0; i < NP; i++) ep[i] = 0;
    for (int i = 0; i < NS; i++) es[i] = 0;
  end

  always @(posedge clk_cpu) begin
    #1; ref_c++;
    for (int i = 0; i < NC; i++) if (cpu_ck_o[i]) ec[i]++;
  end
  always @(posedge clk_pci) begin
    #1; ref_p++;
    for (int i = 0; i < NP; i++) if (pci_ck_o[i]) ep[i]++;
  end
  always @(posedge clk_src) begin
    #1; ref_s++;
    for (int i = 0; i < NS; i++) if (src_ck_o[i]) es[i]++;
  end

  // full-width pulse watch on one processor output (R8)
  always @(posedge cpu_ck_o[0]) begin
    time t0;
    t0 = $time;
    @(negedge cpu_ck_o[0]);
    if ($time - t0 != CLK_PERIOD/2) runts++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input int k);
    cfg_cpu_en        = (k == 3) ? 3'b110 : 3'b111;
    cfg_cpu_stoppable = 3'b011 ^ 3'(k);
    cfg_cpustop_hiz   = 3'(k + 1);
    cfg_pd_hiz_cpu    = k[1];
    cfg_pci_en        = 6'h3F ^ (6'(k) << 2);
    cfg_pci_stoppable = 6'b001111 ^ 6'(k);
    cfg_pci_stop      = (k == 3);
    cfg_src_en        = 8'hFF ^ (8'(k == 1) << 6);
    cfg_src_stoppable = 8'hFF ^ (8'(k) << 1);
    cfg_pcistop_hiz   = k[0];
    cfg_pd_hiz_src    = k[0] ^ k[1];
    cfg_reqa_sel      = 8'h10 | (k[0] ? 8'hFF : 8'h00);
    cfg_reqb_sel      = 8'h80 | (k[1] ? 8'hFF : 8'h00);
  endtask

  task automatic do_reset(input int k);
    rst_n = 0;
    pwrdn = 0; cpu_stop_n = 1; pci_stop_n = 1; clkreq_a_n = 0; clkreq_b_n = 0;
    apply_cfg(k);
    repeat (2) @(posedge clk_pci);
    #2;
    chk("R9", int'(cpu_gate) + int'(pci_gate) + int'(src_gate), 0);
    chk("R9", int'(cpu_hiz) + int'(src_hiz), 0);
    chk("R9", int'(cpu_ck_o) + int'(pci_ck_o) + int'(src_ck_o), 0);
    @(negedge clk_cpu); #1;
    rst_n = 1;
  endtask

  task automatic sweep_point(input int k, input int v);
    int sc, sp, ss;
    int sec [NC];
    int sep [NP];
    int ses [NS];
    logic pd, cs, ps, ra, rb, pcs;
    string tag;
    pd = v[0]; cs = !v[1]; ps = !v[2]; ra = v[3]; rb = v[4];
    @(negedge clk_pci); #1;
    pwrdn = pd; cpu_stop_n = !cs; pci_stop_n = !ps; clkreq_a_n = ra; clkreq_b_n = rb;
    repeat (4) @(posedge clk_pci);
    #2;
    pcs = ps | cfg_pci_stop;
    sc = ref_c; sp = ref_p; ss = ref_s;
    for (int i = 0; i < NC; i++) sec[i] = ec[i];
    for (int i = 0; i < NP; i++) sep[i] = ep[i];
    for (int i = 0; i < NS; i++) ses[i] = es[i];
    #(30*CLK_PERIOD);
    for (int i = 0; i < NC; i++) begin
      logic stop, hz;
      stop = pd | !cfg_cpu_en[i] | (cs & cfg_cpu_stoppable[i]);
      hz = pd ? cfg_pd_hiz_cpu : (cfg_cpu_en[i] & cs & cfg_cpu_stoppable[i] & cfg_cpustop_hiz[i]);
      tag = pd ? "R7" : (!cfg_cpu_en[i] ? "R6" : "R1");
      chk(tag, int'(cpu_gate[i]), int'(!stop));
      chk("R3", int'(cpu_hiz[i]), int'(hz));
      chk("R8", ec[i] - sec[i], stop ? 0 : ref_c - sc);
    end
    for (int i = 0; i < NP; i++) begin
      logic stop;
      stop = pd | !cfg_pci_en[i] | (pcs & cfg_pci_stoppable[i]);
      tag = pd ? "R7" : (!cfg_pci_en[i] ? "R6" : "R2");
      chk(tag, int'(pci_gate[i]), int'(!stop));
      chk("R8", ep[i] - sep[i], stop ? 0 : ref_p - sp);
    end
    for (int i = 0; i < NS; i++) begin
      logic oa, ob, stop, hz;
      oa = ra & cfg_reqa_sel[i] & MA[i];
      ob = rb & cfg_reqb_sel[i] & MB[i];
      stop = pd | !cfg_src_en[i] | (pcs & cfg_src_stoppable[i]) | oa | ob;
      hz = oa | ob | (pd ? cfg_pd_hiz_src : (cfg_src_en[i] & pcs & cfg_src_stoppable[i] & cfg_pcistop_hiz));
      tag = oa ? "R4" : (ob ? "R5" : (pd ? "R7" : (!cfg_src_en[i] ? "R6" : "R2")));
      chk(tag, int'(src_gate[i]), int'(!stop));
      chk("R3", int'(src_hiz[i]), int'(hz));
      chk("R8", es[i] - ses[i], stop ? 0 : ref_s - ss);
    end
  endtask

  initial begin
    #(100000*CLK_PERIOD);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      do_reset(k);
      if (k == 0) begin
        // R9: gate opens at first falling edge after release
        @(posedge clk_cpu); #1;
        chk("R9", int'(cpu_gate), 0);
        @(negedge clk_cpu); #1;
        chk("R9", int'(cpu_gate), 7);
      end
      for (int v = 0; v < 32; v++) sweep_point(k, v);
    end

    // R8 latency: all processor outputs stoppable
    rst_n = 0;
    apply_cfg(0);
    cfg_cpu_stoppable = '1;
    pwrdn = 0; cpu_stop_n = 1; pci_stop_n = 1; clkreq_a_n = 0; clkreq_b_n = 0;
    repeat (2) @(posedge clk_cpu);
    @(negedge clk_cpu); #1;
    rst_n = 1;
    repeat (4) @(posedge clk_cpu);
    @(negedge clk_cpu); #1;
    cpu_stop_n = 0;
    @(posedge clk_cpu); #1; chk("R8", int'(cpu_gate), 7);
    @(posedge clk_cpu); #1; chk("R8", int'(cpu_gate), 7);
    chk("R8", int'(cpu_ck_o), 7);
    @(negedge clk_cpu); #1; chk("R8", int'(cpu_gate), 0);
    repeat (3) @(posedge clk_cpu);
    @(negedge clk_cpu); #1;
    cpu_stop_n = 1;
    @(posedge clk_cpu); #1; chk("R8", int'(cpu_gate), 0);
    @(posedge clk_cpu); #1; chk("R8", int'(cpu_ck_o), 0);
    @(negedge clk_cpu); #1;
    chk("R8", int'(cpu_gate), 7);
    chk("R8", int'(cpu_ck_o), 0);
    @(posedge clk_cpu); #1; chk("R8", int'(cpu_ck_o), 7);
    repeat (4) @(posedge clk_cpu);
    #2;
    chk("R8", runts, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule